// File: doc/BRIEF.md
# Asynchronous Serial Receiver with Sticky Status Byte

This block turns an asynchronous serial line into received characters and keeps a byte-wide status word for the host. The line is oversampled with an enable tick that runs at sixteen times the bit rate. A character has one start bit, a configurable number of data bits sent least significant bit first, an optional parity bit of selectable sense, and one stop bit. Each received character is held in a data register together with a ready flag.

Four receive conditions are latched as sticky flags: overrun, parity mismatch, bad stop bit and line break. A single-cycle read strobe returns the status byte and clears those flags. A level interrupt is raised while any flag is set and the interrupt enable is on. The status byte also shows the inverted level of the active-low terminal-ready input. Its two top bits are fixed at 1, because no transmitter is present.

Top module: `serial_rx_status`

## Requirements
- R1: After reset, statusByte is 0xC0 when dtrN is 1, rxReady is 0 and statusIrq is 0.
- R2: A frame is one low start bit, then DATA_BITS data bits least significant bit first, then an optional parity bit, then a stop bit. Each bit lasts 16 baudTick pulses and is sampled at mid-bit. A completed frame loads rxData and sets rxReady. A dataRd pulse clears rxReady.
- R3: When parityEn is 1, the parity bit is checked. parityOdd=0 means even parity over the data and parity bits, and parityOdd=1 means odd parity. A mismatch sets status bit 1.
- R4: A 0 sampled at the stop position sets status bit 2 (framing). The character is still loaded, unless the frame is a break.
- R5: Status bit 0 (overrun) is set when a character completes while rxReady is still 1 and dataRd is not pulsed in that cycle. The new character replaces the old one.
- R6: A break is a line that stays low from the start bit through the stop position. A break sets status bits 3 and 2, does not set bit 1 and loads no character. No new frame starts until the line has returned high.
- R7: A statusRd pulse clears status bits 3:0 from the next cycle on.
- R8: A condition that arises in the same cycle as a statusRd pulse leaves its flag set.
- R9: statusIrq is 1 exactly when statusIntEn is 1 and any of status bits 3:0 is 1.
- R10: Status bit 4 equals the inverse of dtrN. Bits 7 and 6 read 1 and bit 5 reads 0.
- R11: A low pulse on rxIn shorter than half a bit is discarded as a glitch. The receiver then takes the next valid frame normally.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| baudTick | input | 1 | Oversampling enable, 16 pulses per bit |
| rxIn | input | 1 | Serial line input, idle high |
| parityEn | input | 1 | Parity bit present in the frame |
| parityOdd | input | 1 | 1 selects odd parity, 0 selects even parity |
| statusIntEn | input | 1 | Receive-status interrupt enable |
| dtrN | input | 1 | Active-low terminal-ready input |
| statusRd | input | 1 | Host status read strobe; clears the error flags |
| dataRd | input | 1 | Host data read strobe; clears rxReady |
| rxData | output | DATA_BITS | Last received character |
| rxReady | output | 1 | An unread character is held |
| statusByte | output | 8 | {1,1,0,~dtrN,break,framing,parity,overrun} |
| statusIrq | output | 1 | Receive-status interrupt |

## Verification
The hardest case to reach is a status read that lands on the exact clock edge where a flag is being set. The ports give no sign of that internal cycle. The bench first sends a frame with a bad parity bit and no read, and records the clock on which the parity flag first appears. It then resends the identical frame with the same tick phase and places the read strobe on the cycle just before that clock. The flag must survive that read and must clear on the next read. The break case is reached by holding the line low for more than a whole frame. The bench then clears the flags while the line is still low, to show that no false start follows.

// File: rtl/rxs_pkg.sv
package rxs_pkg;

  // Strobes sent from the control FSM to the datapath
  typedef struct packed {
    logic shiftBit;    // sample a data bit into the shift register
    logic takeParity;  // sample the parity bit
    logic loadChar;    // character complete, move it to the data register
    logic frameErr;    // stop position sampled low, not a break
    logic breakDet;    // whole frame low
  } rxStrobe_t;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_START,
    ST_DATA,
    ST_PARITY,
    ST_STOP,
    ST_BRKWAIT
  } rxState_t;

  localparam int FLAG_OVR = 0;
  localparam int FLAG_PAR = 1;
  localparam int FLAG_FRM = 2;
  localparam int FLAG_BRK = 3;
  localparam int NUM_FLAGS = 4;

endpackage

// File: rtl/rxs_ctrl.sv
module rxs_ctrl
  import rxs_pkg::*;
#(
  parameter int DATA_BITS = 8,
  parameter int OS_RATE   = 16
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       baudTick,
  input  logic       rxS,
  input  logic       parityEn,
  output rxStrobe_t  strb
);

  localparam int CW   = $clog2(OS_RATE);
  localparam int BW   = $clog2(DATA_BITS + 1);
  localparam int HALF = OS_RATE / 2;

  rxState_t        state;
  logic [CW-1:0]   tickCnt;
  logic [BW-1:0]   bitCnt;
  logic            sawHigh;
  logic            bitEnd;
  logic            halfEnd;

  assign bitEnd  = baudTick && (tickCnt == CW'(OS_RATE - 1));
  assign halfEnd = baudTick && (tickCnt == CW'(HALF - 1));

  always_comb begin
    strb = '0;
    if (bitEnd) begin
      unique case (state)
        ST_DATA:   strb.shiftBit   = 1'b1;
        ST_PARITY: strb.takeParity = 1'b1;
        ST_STOP: begin
          if (rxS) begin
            strb.loadChar = 1'b1;
          end else if (!sawHigh) begin
            strb.breakDet = 1'b1;
          end else begin
            strb.frameErr = 1'b1;
            strb.loadChar = 1'b1;
          end
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state   <= ST_IDLE;
      tickCnt <= '0;
      bitCnt  <= '0;
      sawHigh <= 1'b0;
    end else begin
      unique case (state)
        ST_IDLE: begin
          if (baudTick && !rxS) begin
            state   <= ST_START;
            tickCnt <= '0;
          end
        end
        ST_START: begin
          if (baudTick) begin
            if (rxS) begin
              state <= ST_IDLE;
            end else if (halfEnd) begin
              state   <= ST_DATA;
              tickCnt <= '0;
              bitCnt  <= '0;
              sawHigh <= 1'b0;
            end else begin
              tickCnt <= tickCnt + 1'b1;
            end
          end
        end
        ST_DATA: begin
          if (bitEnd) begin
            tickCnt <= '0;
            sawHigh <= sawHigh | rxS;
            if (bitCnt == BW'(DATA_BITS - 1)) begin
              state <= parityEn ? ST_PARITY : ST_STOP;
            end else begin
              bitCnt <= bitCnt + 1'b1;
            end
          end else if (baudTick) begin
            tickCnt <= tickCnt + 1'b1;
          end
        end
        ST_PARITY: begin
          if (bitEnd) begin
            tickCnt <= '0;
            sawHigh <= sawHigh | rxS;
            state   <= ST_STOP;
          end else if (baudTick) begin
            tickCnt <= tickCnt + 1'b1;
          end
        end
        ST_STOP: begin
          if (bitEnd) begin
            tickCnt <= '0;
            state   <= (!rxS && !sawHigh) ? ST_BRKWAIT : ST_IDLE;
          end else if (baudTick) begin
            tickCnt <= tickCnt + 1'b1;
          end
        end
        ST_BRKWAIT: begin
          if (rxS) state <= ST_IDLE;
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  // R6
  brkHold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_BRKWAIT && !rxS) |=> (state == ST_BRKWAIT));

  // R11
  glitchDrop_chk: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_START && baudTick && rxS) |=> (state == ST_IDLE));

endmodule

// File: rtl/rxs_datapath.sv
module rxs_datapath
  import rxs_pkg::*;
#(
  parameter int DATA_BITS = 8
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  logic                  rxS,
  input  rxStrobe_t             strb,
  input  logic                  parityEn,
  input  logic                  parityOdd,
  input  logic                  statusRd,
  input  logic                  dataRd,
  output logic [DATA_BITS-1:0]  rxData,
  output logic                  rxReady,
  output logic [NUM_FLAGS-1:0]  errFlags
);

  logic [DATA_BITS-1:0] shiftReg;
  logic                 parBit;
  logic                 parMismatch;
  logic [NUM_FLAGS-1:0] setBits;

  assign parMismatch = (^shiftReg) ^ parBit ^ parityOdd;

  always_comb begin
    setBits           = '0;
    setBits[FLAG_OVR] = strb.loadChar && rxReady && !dataRd;
    setBits[FLAG_PAR] = strb.loadChar && parityEn && parMismatch;
    setBits[FLAG_FRM] = strb.frameErr || strb.breakDet;
    setBits[FLAG_BRK] = strb.breakDet;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      shiftReg <= '0;
      parBit   <= 1'b0;
      rxData   <= '0;
      rxReady  <= 1'b0;
      errFlags <= '0;
    end else begin
      if (strb.shiftBit)   shiftReg <= {rxS, shiftReg[DATA_BITS-1:1]};
      if (strb.takeParity) parBit   <= rxS;
      if (strb.loadChar) begin
        rxData  <= shiftReg;
        rxReady <= 1'b1;
      end else if (dataRd) begin
        rxReady <= 1'b0;
      end
      errFlags <= (errFlags & ~{NUM_FLAGS{statusRd}}) | setBits;
    end
  end

  // R5
  overrun_chk: assert property (@(posedge clk) disable iff (!rstN)
    (strb.loadChar && rxReady && !dataRd) |=> errFlags[FLAG_OVR]);

  // R8
  setWins_chk: assert property (@(posedge clk) disable iff (!rstN)
    (strb.frameErr || strb.breakDet) |=> errFlags[FLAG_FRM]);

  // R7
  clearOnRead_chk: assert property (@(posedge clk) disable iff (!rstN)
    (statusRd && !strb.loadChar && !strb.frameErr && !strb.breakDet)
      |=> (errFlags == '0));

  // R2
  readyRise_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(rxReady) |-> $past(strb.loadChar));

endmodule

// File: rtl/serial_rx_status.sv
module serial_rx_status
  import rxs_pkg::*;
#(
  parameter int DATA_BITS   = 8,
  parameter int OS_RATE     = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 baudTick,
  input  logic                 rxIn,
  input  logic                 parityEn,
  input  logic                 parityOdd,
  input  logic                 statusIntEn,
  input  logic                 dtrN,
  input  logic                 statusRd,
  input  logic                 dataRd,
  output logic [DATA_BITS-1:0] rxData,
  output logic                 rxReady,
  output logic [7:0]           statusByte,
  output logic                 statusIrq
);

  logic [SYNC_STAGES-1:0] syncQ;
  logic                   rxS;
  rxStrobe_t              strb;
  logic [NUM_FLAGS-1:0]   errFlags;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) syncQ <= '1;
    else       syncQ <= {syncQ[SYNC_STAGES-2:0], rxIn};
  end
  assign rxS = syncQ[SYNC_STAGES-1];

  rxs_ctrl #(.DATA_BITS(DATA_BITS), .OS_RATE(OS_RATE)) u_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .baudTick (baudTick),
    .rxS      (rxS),
    .parityEn (parityEn),
    .strb     (strb)
  );

  rxs_datapath #(.DATA_BITS(DATA_BITS)) u_dp (
    .clk       (clk),
    .rstN      (rstN),
    .rxS       (rxS),
    .strb      (strb),
    .parityEn  (parityEn),
    .parityOdd (parityOdd),
    .statusRd  (statusRd),
    .dataRd    (dataRd),
    .rxData    (rxData),
    .rxReady   (rxReady),
    .errFlags  (errFlags)
  );

  assign statusByte = {2'b11, 1'b0, ~dtrN, errFlags};
  assign statusIrq  = statusIntEn && (|errFlags);

endmodule

// File: tb/serial_rx_status_bench.sv
`timescale 1ns/1ps
module serial_rx_status_bench;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       baudTick = 1'b1;
  logic       rxLine = 1'b1;
  logic       parityEn = 1'b0;
  logic       parityOdd = 1'b0;
  logic       statusIntEn = 1'b1;
  logic       dtrN = 1'b1;
  logic       statusRd = 1'b0;
  logic       dataRd = 1'b0;
  logic [7:0] rxData;
  logic       rxReady;
  logic [7:0] statusByte;
  logic       statusIrq;

  int testCnt = 0;
  int failCnt = 0;

  always #10 clk = ~clk;

  serial_rx_status u_serial_rx_status (
    .clk(clk), .rstN(rstN), .baudTick(baudTick), .rxIn(rxLine),
    .parityEn(parityEn), .parityOdd(parityOdd), .statusIntEn(statusIntEn),
    .dtrN(dtrN), .statusRd(statusRd), .dataRd(dataRd),
    .rxData(rxData), .rxReady(rxReady), .statusByte(statusByte),
    .statusIrq(statusIrq)
  );

  // {data[15:8], parityEn, parityOdd, flipParity, badStop, expected flags[3:0]}
  localparam logic [15:0] VEC [7] = '{
    {8'hB4, 4'b0000, 4'b0000},
    {8'h3A, 4'b1000, 4'b0000},
    {8'h3A, 4'b1010, 4'b0010},
    {8'h83, 4'b1100, 4'b0000},
    {8'h83, 4'b1110, 4'b0010},
    {8'h55, 4'b0001, 4'b0100},
    {8'hF0, 4'b1001, 4'b0100}
  };

  task automatic check(input string tag, input int act, input int exp);
    testCnt++;
    if (act != exp) begin
      failCnt++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
    end
  endtask

  task automatic sendFrame(input logic [7:0] d, input bit pen, input bit podd,
                           input bit flip, input bit badStop,
                           input int rdAt, output int riseAt);
    logic [15:0] bits;
    int n;
    int idx;
    bits = '1;
    bits[0] = 1'b0;
    for (int i = 0; i < 8; i++) bits[1+i] = d[i];
    n = 9;
    if (pen) begin
      bits[9] = (^d) ^ podd ^ flip;
      n = 10;
    end
    bits[n] = !badStop;
    n++;
    idx = 0;
    riseAt = -1;
    for (int b = 0; b < n + 2; b++) begin
      for (int t = 0; t < 16; t++) begin
        @(negedge clk);
        idx++;
        rxLine = (b < n) ? bits[b] : 1'b1;
        statusRd = (idx == rdAt);
        if (riseAt < 0 && statusByte[1]) riseAt = idx;
      end
    end
    statusRd = 1'b0;
  endtask

  task automatic readBoth();
    @(negedge clk);
    statusRd = 1'b1;
    dataRd = 1'b1;
    @(negedge clk);
    statusRd = 1'b0;
    dataRd = 1'b0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    failCnt++;
    $display("FAIL watchdog expired");
    $display("[TB] %0d tests run, %0d failed", testCnt, failCnt);
    $finish;
  end

  initial begin
    int rise;
    int rise2;
    logic [7:0] d;
    logic [3:0] nib;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    // R1 reset state
    check("R1 status", statusByte, 8'hC0);
    check("R1 ready", rxReady, 0);
    check("R1 irq", statusIrq, 0);

    // R10 terminal-ready level inverted
    dtrN = 1'b0;
    @(negedge clk);
    check("R10 dtr low", statusByte, 8'hD0);
    dtrN = 1'b1;
    @(negedge clk);
    check("R10 dtr high", statusByte, 8'hC0);

    // Table of frames (R2, R3, R4, R9)
    for (int v = 0; v < 7; v++) begin
      d = VEC[v][15:8];
      nib = VEC[v][3:0];
      parityEn = VEC[v][7];
      parityOdd = VEC[v][6];
      sendFrame(d, VEC[v][7], VEC[v][6], VEC[v][5], VEC[v][4], -1, rise);
      check("R2 data", rxData, d);
      check("R2 ready", rxReady, 1);
      check("R3/R4 flags", statusByte[3:0], nib);
      check("R9 irq", statusIrq, (nib != 0));
      readBoth();
      check("R7 cleared", statusByte[3:0], 0);
      check("R2 ready cleared", rxReady, 0);
    end
    parityEn = 1'b0;
    parityOdd = 1'b0;

    // R11 glitch shorter than half a bit
    @(negedge clk);
    rxLine = 1'b0;
    repeat (5) @(negedge clk);
    rxLine = 1'b1;
    repeat (60) @(negedge clk);
    check("R11 no char", rxReady, 0);
    check("R11 no flags", statusByte, 8'hC0);
    sendFrame(8'h6E, 0, 0, 0, 0, -1, rise);
    check("R11 next frame", rxData, 8'h6E);
    readBoth();

    // R5 overrun
    sendFrame(8'h12, 0, 0, 0, 0, -1, rise);
    sendFrame(8'h34, 0, 0, 0, 0, -1, rise);
    check("R5 overrun flag", statusByte[3:0], 4'b0001);
    check("R5 newest data", rxData, 8'h34);
    readBoth();

    // R6 break with interrupt disabled (R9)
    statusIntEn = 1'b0;
    @(negedge clk);
    rxLine = 1'b0;
    repeat (13 * 16) @(negedge clk);
    check("R6 break flags", statusByte[3:0], 4'b1100);
    check("R6 no char", rxReady, 0);
    check("R9 irq disabled", statusIrq, 0);
    statusRd = 1'b1;
    @(negedge clk);
    statusRd = 1'b0;
    repeat (40) @(negedge clk);
    check("R6 wait for high", statusByte[3:0], 0);
    check("R6 still no char", rxReady, 0);
    rxLine = 1'b1;
    statusIntEn = 1'b1;
    repeat (40) @(negedge clk);
    sendFrame(8'h5A, 0, 0, 0, 0, -1, rise);
    check("R6 after break data", rxData, 8'h5A);
    check("R6 after break flags", statusByte[3:0], 0);
    readBoth();

    // R8 set in the same cycle as a status read
    parityEn = 1'b1;
    repeat (8) @(negedge clk);
    sendFrame(8'h0F, 1, 0, 1, 0, -1, rise);
    check("R8 dry run saw flag", (rise > 1), 1);
    readBoth();
    repeat (30) @(negedge clk);
    sendFrame(8'h0F, 1, 0, 1, 0, rise - 1, rise2);
    @(negedge clk);
    check("R8 flag survives read", statusByte[1], 1);
    statusRd = 1'b1;
    @(negedge clk);
    statusRd = 1'b0;
    @(negedge clk);
    check("R7 later read clears", statusByte[3:0], 0);
    parityEn = 1'b0;

    $display("[TB] %0d tests run, %0d failed", testCnt, failCnt);
    $finish;
  end

endmodule